// File: doc/BRIEF.md
# Clock Synthesizer Parameter Register Bank

This block holds the divider and multiplier settings for two frequency synthesizers: one for the memory clock and one for the pixel clock. A host programs it through an index/data pair. A write with the data select low loads the index register. A write with the data select high stores the byte at the register the index points to.

A key register guards the parameter and control locations. Once the key holds the unlock value, the host writes each 16-bit parameter word as two bytes into a pending store. Nothing reaches the synthesizers until the host drives a control bit low, high and low again. When that happens, both pending words are copied to the active set in one cycle, and a single-cycle load pulse tells the synthesizers to relock.

The outputs are already decoded into actual values: the N1 divider, the M multiplier and the post-divide factor for each synthesizer. A flag marks an active setting that holds a zero code.

Top module: `clksyn_regs`

## Requirements
- R1: After reset the bank is locked and `load_pulse` and `setting_invalid` are low. The memory clock shows divider 14, multiplier 60 and post-divide 4. The pixel clock shows divider 3, multiplier 87 and post-divide 4.
- R2: Writing 0x06 at index 0x08 unlocks the bank. Writing any other value there (0x00 included) locks it.
- R3: While the bank is locked, data writes to indices 0x10–0x13 and 0x15 have no effect, neither on the pending words nor on the commit sequence.
- R4: The low byte of a parameter word goes to the even index (0x10 memory, 0x12 pixel) and the high byte to the next odd index. In the word, N1 is bits 4:0, N2 is bits 7:5 and M is bits 14:8. Bit 15 is ignored.
- R5: Pending writes leave the active outputs unchanged until a commit completes.
- R6: Among writes to index 0x15, only bit 5 counts; all other bits are ignored. A commit needs a 0, then a 1, then a 0. Extra 0s before the 1 are allowed. A second consecutive 1 restarts detection.
- R7: The write that completes the sequence copies both pending words to the active set at its clock edge. At that same edge `load_pulse` rises, and it stays high for exactly one cycle.
- R8: The active divider equals stored N1 + 2, and the active multiplier equals stored M + 2.
- R9: The post-divide factor is 2^code for N2 codes 0–3 and 8 for codes 4–7.
- R10: `setting_invalid` is high exactly when either active word holds N1 = 0 or M = 0. In that case the decoded value is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Write strobe |
| host_sel_data | input | 1 | 0: write index register, 1: write data at current index |
| host_wdata | input | 8 | Write data |
| mem_n1_div | output | 6 | Memory clock actual N1 divider |
| mem_m_mul | output | 8 | Memory clock actual M multiplier |
| mem_post_div | output | 4 | Memory clock post-divide factor |
| vid_n1_div | output | 6 | Pixel clock actual N1 divider |
| vid_m_mul | output | 8 | Pixel clock actual M multiplier |
| vid_post_div | output | 4 | Pixel clock post-divide factor |
| load_pulse | output | 1 | One-cycle commit pulse |
| setting_invalid | output | 1 | An active N1 or M code is zero |

## Verification
The bench goes after several specific corner cases:
- **Broken sequence (0,1,1,0).** A design that keeps its place after the repeated 1 would commit on the final 0.
- **Strobe byte 0xDF.** The strobe bit is clear but every other bit is set. A decoder that looks at the whole byte would miss this commit.
- **Writes while locked.** A design with no guard would show the values written while locked after the next commit.
- **Wrong key (0x07).** A design that accepts any key, or any nonzero key, would commit here.
- **N2 codes above 3.** A design that wraps these codes would give a post-divide of 1 or 2 instead of 8.
- **Zero codes.** An active word with a zero code must decode to 2 and raise the invalid flag.
- **Bit 15 set.** It must not leak into M.

// File: rtl/clksyn_pkg.sv
package clksyn_pkg;
  localparam int N1_W = 5;
  localparam int N2_W = 3;
  localparam int M_W = 7;
  localparam int WORD_W = N1_W + N2_W + M_W;
  localparam int N1_ACT_W = N1_W + 1;
  localparam int M_ACT_W = M_W + 1;
  localparam int POST_W = 4;
  localparam int SYN_COUNT = 2;

  typedef struct packed {
    logic [M_W-1:0]  m;
    logic [N2_W-1:0] n2;
    logic [N1_W-1:0] n1;
  } syn_word_t;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_LOW  = 2'd1,
    SEQ_HIGH = 2'd2
  } seq_state_t;

  // stored code plus two, zero maps to two
  function automatic logic [N1_ACT_W-1:0] n1_actual(input logic [N1_W-1:0] code);
    return {1'b0, code} + N1_ACT_W'(2);
  endfunction

  function automatic logic [M_ACT_W-1:0] m_actual(input logic [M_W-1:0] code);
    return {1'b0, code} + M_ACT_W'(2);
  endfunction

  // codes 0..3 give 2^code, anything above saturates at 8
  function automatic logic [POST_W-1:0] post_factor(input logic [N2_W-1:0] code);
    if (code > N2_W'(3)) return POST_W'(8);
    return POST_W'(1) << code[1:0];
  endfunction

  function automatic logic word_has_zero(input syn_word_t w);
    return (w.n1 == '0) || (w.m == '0);
  endfunction
endpackage

// File: rtl/clksyn_key_guard.sv
module clksyn_key_guard #(
  parameter int DATA_W = 8,
  parameter int KEY    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              unlocked
);
  localparam logic [DATA_W-1:0] KEY_V = DATA_W'(KEY);

  always_ff @(posedge clk) begin
    if (!rst_n)      unlocked <= 1'b0;
    else if (key_wr) unlocked <= (wdata == KEY_V);
  end

  assert_key_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && wdata == KEY_V) |=> unlocked);
  assert_key_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && wdata != KEY_V) |=> !unlocked);
endmodule

// File: rtl/clksyn_strobe_seq.sv
module clksyn_strobe_seq
  import clksyn_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic strobe_bit,
  output logic commit,
  output logic load_pulse
);
  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    commit  = 1'b0;
    if (ctl_wr) begin
      case (state_q)
        SEQ_IDLE: state_d = strobe_bit ? SEQ_IDLE : SEQ_LOW;
        SEQ_LOW:  state_d = strobe_bit ? SEQ_HIGH : SEQ_LOW;
        SEQ_HIGH: begin
          state_d = SEQ_IDLE;
          commit  = !strobe_bit;
        end
        default:  state_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= SEQ_IDLE;
      load_pulse <= 1'b0;
    end else begin
      state_q    <= state_d;
      load_pulse <= commit;
    end
  end

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |=> !load_pulse);
  assert_commit_needs_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (state_q == SEQ_HIGH && ctl_wr && !strobe_bit));
  assert_restart_on_double_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && strobe_bit && state_q == SEQ_HIGH) |=> state_q == SEQ_IDLE);
endmodule

// File: rtl/clksyn_param_bank.sv
module clksyn_param_bank
  import clksyn_pkg::*;
#(
  parameter int                DATA_W     = 8,
  parameter logic [WORD_W-1:0] RESET_WORD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  input  logic              commit,
  output syn_word_t         pending,
  output syn_word_t         active
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= syn_word_t'(RESET_WORD);
      active  <= syn_word_t'(RESET_WORD);
    end else begin
      if (wr_lo) {pending.n2, pending.n1} <= wdata[N1_W+N2_W-1:0];
      if (wr_hi) pending.m <= wdata[M_W-1:0];
      if (commit) active <= pending;
    end
  end

  assert_commit_copies_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> active == $past(pending));
  assert_active_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(active));
endmodule

// File: rtl/clksyn_regs.sv
module clksyn_regs
  import clksyn_pkg::*;
#(
  parameter int                          DATA_W       = 8,
  parameter int                          IDX_W        = 8,
  parameter int                          KEY_IDX      = 8'h08,
  parameter int                          UNLOCK_KEY   = 6,
  parameter int                          SYN_BASE_IDX = 8'h10,
  parameter int                          CTL_IDX      = 8'h15,
  parameter int                          STROBE_BIT   = 5,
  parameter logic [SYN_COUNT*WORD_W-1:0] RESET_WORDS  = {15'h5541, 15'h3A4C}
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_wr,
  input  logic                host_sel_data,
  input  logic [DATA_W-1:0]   host_wdata,
  output logic [N1_ACT_W-1:0] mem_n1_div,
  output logic [M_ACT_W-1:0]  mem_m_mul,
  output logic [POST_W-1:0]   mem_post_div,
  output logic [N1_ACT_W-1:0] vid_n1_div,
  output logic [M_ACT_W-1:0]  vid_m_mul,
  output logic [POST_W-1:0]   vid_post_div,
  output logic                load_pulse,
  output logic                setting_invalid
);
  localparam logic [IDX_W-1:0] KEY_IDX_V = IDX_W'(KEY_IDX);
  localparam logic [IDX_W-1:0] CTL_IDX_V = IDX_W'(CTL_IDX);

  logic [IDX_W-1:0] idx_q;
  logic             data_wr;
  logic             unlocked;
  logic             ctl_wr;
  logic             commit;

  syn_word_t                 pend   [SYN_COUNT];
  syn_word_t                 act    [SYN_COUNT];
  logic [SYN_COUNT-1:0]      wr_lo, wr_hi, bad;
  logic [N1_ACT_W-1:0]       n1_div [SYN_COUNT];
  logic [M_ACT_W-1:0]        m_mul  [SYN_COUNT];
  logic [POST_W-1:0]         post   [SYN_COUNT];

  always_ff @(posedge clk) begin
    if (!rst_n)                        idx_q <= '0;
    else if (host_wr && !host_sel_data) idx_q <= host_wdata;
  end

  assign data_wr = host_wr && host_sel_data;
  assign ctl_wr  = data_wr && unlocked && (idx_q == CTL_IDX_V);

  clksyn_key_guard #(.DATA_W(DATA_W), .KEY(UNLOCK_KEY)) u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (data_wr && (idx_q == KEY_IDX_V)),
    .wdata    (host_wdata),
    .unlocked (unlocked)
  );

  clksyn_strobe_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr     (ctl_wr),
    .strobe_bit (host_wdata[STROBE_BIT]),
    .commit     (commit),
    .load_pulse (load_pulse)
  );

  for (genvar g = 0; g < SYN_COUNT; g++) begin : g_syn
    localparam logic [IDX_W-1:0] LO_IDX = IDX_W'(SYN_BASE_IDX + 2 * g);
    localparam logic [IDX_W-1:0] HI_IDX = IDX_W'(SYN_BASE_IDX + 2 * g + 1);

    assign wr_lo[g] = data_wr && unlocked && (idx_q == LO_IDX);
    assign wr_hi[g] = data_wr && unlocked && (idx_q == HI_IDX);

    clksyn_param_bank #(
      .DATA_W     (DATA_W),
      .RESET_WORD (RESET_WORDS[g*WORD_W +: WORD_W])
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_lo   (wr_lo[g]),
      .wr_hi   (wr_hi[g]),
      .wdata   (host_wdata),
      .commit  (commit),
      .pending (pend[g]),
      .active  (act[g])
    );

    assign n1_div[g] = n1_actual(act[g].n1);
    assign m_mul[g]  = m_actual(act[g].m);
    assign post[g]   = post_factor(act[g].n2);
    assign bad[g]    = word_has_zero(act[g]);

    assert_locked_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && !unlocked && (idx_q == LO_IDX || idx_q == HI_IDX)) |=> $stable(pend[g]));
    assert_post_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(post[g]) == 1);
  end

  assign mem_n1_div      = n1_div[0];
  assign mem_m_mul       = m_mul[0];
  assign mem_post_div    = post[0];
  assign vid_n1_div      = n1_div[1];
  assign vid_m_mul       = m_mul[1];
  assign vid_post_div    = post[1];
  assign setting_invalid = |bad;

  assert_locked_no_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !unlocked && idx_q == CTL_IDX_V) |=> !load_pulse);
  assert_invalid_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    setting_invalid == (mem_n1_div == 6'd2 || mem_m_mul == 8'd2 ||
                        vid_n1_div == 6'd2 || vid_m_mul == 8'd2));
  assert_decode_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_n1_div >= 6'd2) && (vid_n1_div >= 6'd2) && (mem_m_mul >= 8'd2) && (vid_m_mul >= 8'd2));
endmodule

// File: tb/test_clksyn_regs.sv
module test_clksyn_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic       host_sel_data = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [5:0] mem_n1_div, vid_n1_div;
  logic [7:0] mem_m_mul, vid_m_mul;
  logic [3:0] mem_post_div, vid_post_div;
  logic       load_pulse, setting_invalid;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  clksyn_regs i_clksyn_regs (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel_data(host_sel_data),
    .host_wdata(host_wdata), .mem_n1_div(mem_n1_div), .mem_m_mul(mem_m_mul),
    .mem_post_div(mem_post_div), .vid_n1_div(vid_n1_div), .vid_m_mul(vid_m_mul),
    .vid_post_div(vid_post_div), .load_pulse(load_pulse), .setting_invalid(setting_invalid)
  );

  typedef struct packed {
    logic [15:0] mem_w;
    logic [15:0] vid_w;
    logic [5:0]  mem_n1;
    logic [7:0]  mem_m;
    logic [3:0]  mem_p;
    logic [5:0]  vid_n1;
    logic [7:0]  vid_m;
    logic [3:0]  vid_p;
    logic        bad;
  } vec_t;

  // R4 R8 R9 R10 stimulus and expected decodes
  localparam vec_t VECS [4] = '{
    '{16'h2A05, 16'h7FFF, 6'd7,  8'd44,  4'd1, 6'd33, 8'd129, 4'd8, 1'b0},
    '{16'h0160, 16'h1022, 6'd2,  8'd3,   4'd8, 6'd4,  8'd18,  4'd2, 1'b1},
    '{16'h8081, 16'h0141, 6'd3,  8'd2,   4'd8, 6'd3,  8'd3,   4'd4, 1'b1},
    '{16'h643F, 16'hC8A3, 6'd33, 8'd102, 4'd2, 6'd5,  8'd74,  4'd8, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic host_write(input logic sel, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_sel_data = sel; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic reg_write(input logic [7:0] idx, input logic [7:0] d);
    host_write(1'b0, idx);
    host_write(1'b1, d);
  endtask

  task automatic check_mem(input string req, input int n1, input int m, input int p);
    check({req, " mem n1"}, mem_n1_div, n1);
    check({req, " mem m"}, mem_m_mul, m);
    check({req, " mem post"}, mem_post_div, p);
  endtask

  task automatic check_vid(input string req, input int n1, input int m, input int p);
    check({req, " vid n1"}, vid_n1_div, n1);
    check({req, " vid m"}, vid_m_mul, m);
    check({req, " vid post"}, vid_post_div, p);
  endtask

  task automatic strobe3(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    reg_write(8'h15, a);
    reg_write(8'h15, b);
    reg_write(8'h15, c);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_mem("R1", 14, 60, 4);
    check_vid("R1", 3, 87, 4);
    check("R1 load", load_pulse, 0);
    check("R1 invalid", setting_invalid, 0);
    // R1 locked after reset: a strobe sequence must not commit
    strobe3(8'h00, 8'h20, 8'h00);
    check("R1 locked strobe", load_pulse, 0);

    // table walk: R4 R6 R7 R8 R9 R10
    foreach (VECS[i]) begin
      reg_write(8'h08, 8'h06);
      reg_write(8'h10, VECS[i].mem_w[7:0]);
      reg_write(8'h11, VECS[i].mem_w[15:8]);
      reg_write(8'h12, VECS[i].vid_w[7:0]);
      reg_write(8'h13, VECS[i].vid_w[15:8]);
      strobe3(8'h00, 8'h20, 8'h00);
      check("R7 load pulse", load_pulse, 1);
      check_mem("R4 R8 R9", VECS[i].mem_n1, VECS[i].mem_m, VECS[i].mem_p);
      check_vid("R4 R8 R9", VECS[i].vid_n1, VECS[i].vid_m, VECS[i].vid_p);
      check("R10 invalid", setting_invalid, VECS[i].bad);
      @(negedge clk);
      check("R7 pulse width", load_pulse, 0);
    end

    // R5 pending kept apart from active
    reg_write(8'h10, 8'h03);
    reg_write(8'h11, 8'h02);
    check_mem("R5", 33, 102, 2);
    // R6 broken order 0,1,1,0 then no commit
    reg_write(8'h15, 8'h00);
    reg_write(8'h15, 8'h20);
    reg_write(8'h15, 8'h20);
    reg_write(8'h15, 8'h00);
    check("R6 broken order", load_pulse, 0);
    check_mem("R6 broken order", 33, 102, 2);
    // R6 pending 0 continues: 1 then 0xDF (bit5 clear, others set) commits
    reg_write(8'h15, 8'h20);
    reg_write(8'h15, 8'hDF);
    check("R6 other bits ignored", load_pulse, 1);
    check_mem("R6 commit", 5, 4, 1);
    check_vid("R6 commit", 5, 74, 8);

    // R2 R3 locked writes ignored
    reg_write(8'h08, 8'h00);
    reg_write(8'h10, 8'h05);
    reg_write(8'h11, 8'h05);
    strobe3(8'h00, 8'h20, 8'h00);
    check("R3 locked strobe", load_pulse, 0);
    check_mem("R3 locked", 5, 4, 1);
    reg_write(8'h08, 8'h07);
    strobe3(8'h00, 8'h20, 8'h00);
    check("R2 wrong key", load_pulse, 0);
    reg_write(8'h08, 8'h06);
    strobe3(8'h00, 8'h20, 8'h00);
    check("R2 key unlock", load_pulse, 1);
    check_mem("R3 pending untouched", 5, 4, 1);

    // R1 reset restores defaults
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_mem("R1 re-reset", 14, 60, 4);
    check_vid("R1 re-reset", 3, 87, 4);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule